// File: doc/BRIEF.md
# I2C Clock-Stretch Timeout Detector

This block sits beside the SCL generator of an I2C master. When the master lets SCL go high, a target may hold the line low to stretch the clock. The detector counts how long that stretch lasts, in whole SCL periods. It uses the divider tick that the SCL generator already produces. If the stretch reaches a programmable 16-bit limit, the block judges the target unresponsive.

On a timeout the block sets a sticky status bit. Software clears that bit by writing one to it. In the same cycle that the status bit rises, the block sends a single-cycle abort request to the transfer controller. The controller then ends the transfer and reports it as done. A limit of zero turns detection off. The observed SCL level passes through a short synchronizer before it is used. Recovering the bus after a timeout is left to other logic.

Top module: `scl_stretch_guard`

## Requirements
- R1: After reset, `tmo_status_o` and `abort_req_o` are both 0.
- R2: The stretch counter advances by one on each cycle where `period_tick_i` is 1, while `scl_release_i` is 1 and the synchronized `scl_sense_i` is 0. The status sets after exactly `stretch_limit_i` such ticks, and not after one fewer.
- R3: A high level on `scl_sense_i` during a stretch returns the count to zero, so ticks from before the high level do not add to ticks after it.
- R4: While `scl_release_i` is 0 (the master drives SCL low), the count stays at zero, however many ticks arrive.
- R5: A `stretch_limit_i` of 0 disables detection: no status and no abort, however long the stretch.
- R6: Once set, `tmo_status_o` stays 1 after SCL rises or the stretch ends, until it is cleared.
- R7: A one-cycle pulse on `tmo_clear_i` (write-one-to-clear) drops `tmo_status_o` to 0 on the next cycle when no timeout is pending.
- R8: `abort_req_o` is high for exactly one cycle per timeout event, in the same cycle that `tmo_status_o` first reads 1.
- R9: If a clear arrives while the stretch is still at or beyond the limit, the set wins: the status stays 1 and no second abort is issued.
- R10: The count saturates at the limit and does not wrap. The full-scale limit 16'hFFFF times out after exactly 65535 ticks, with a single abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| stretch_limit_i | input | 16 | Timeout limit in SCL periods; 0 disables |
| period_tick_i | input | 1 | One-cycle pulse per full SCL period from the clock generator |
| scl_release_i | input | 1 | 1 when the master releases SCL high, 0 when it drives SCL low |
| scl_sense_i | input | 1 | SCL level seen on the pin (asynchronous) |
| tmo_clear_i | input | 1 | Write-one-to-clear strobe for the status bit |
| tmo_status_o | output | 1 | Sticky timeout status |
| abort_req_o | output | 1 | One-cycle abort request to the transfer controller |

## Verification
The bench builds the block with its default 16-bit limit width and a two-stage synchronizer. It allows for the two-cycle delay between the pin and the counter when it places its samples.

Small limits such as 3 test the boundary between one tick too few and the exact tick count. The tests also cover resets of the count partway through a stretch, and a clear that arrives during a stretch still past the limit.

For the full-scale limit, the bench holds the tick high on every cycle. This makes the 65535-period case short enough to run, and lets the bench show that the count saturates at the limit rather than wrapping.

// File: rtl/scl_stretch_pkg.sv
package scl_stretch_pkg;

    localparam int DEF_LIMIT_W     = 16;
    localparam int DEF_SYNC_STAGES = 2;

    typedef struct packed {
        logic flag;
        logic abort;
    } tmo_state_t;

endpackage

// File: rtl/scl_sense_sync.sv
module scl_sense_sync #(
    parameter int  STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic level_o
);

    generate
        if (STAGES == 0) begin : g_bypass
            assign level_o = pin_i;
        end else begin : g_chain
            logic [STAGES-1:0] sh_d, sh_q;

            always_comb begin
                sh_d[0] = pin_i;
                for (int i = 1; i < STAGES; i++) begin
                    sh_d[i] = sh_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sh_q <= {STAGES{RESET_VAL}};
                else        sh_q <= sh_d;
            end

            assign level_o = sh_q[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/stretch_counter.sv
module stretch_counter #(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIMIT_W-1:0] limit_i,
    input  logic               tick_i,
    input  logic               stretch_i,
    output logic               hit_o
);

    typedef struct packed {
        logic [LIMIT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;
    logic       armed;

    always_comb begin
        s_d   = s_q;
        armed = stretch_i && (limit_i != '0);
        if (!armed) begin
            s_d.cnt = '0;
        end else if (tick_i && (s_q.cnt < limit_i)) begin
            s_d.cnt = s_q.cnt + LIMIT_W'(1);
        end
        hit_o = armed && (s_q.cnt >= limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_i && limit_i != '0 && tick_i && s_q.cnt < limit_i) |=> (s_q.cnt == $past(s_q.cnt) + LIMIT_W'(1))); // R2
    AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (!stretch_i) |=> (s_q.cnt == '0)); // R3
    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_i && s_q.cnt == limit_i && limit_i != '0 && $stable(limit_i)) |=> (s_q.cnt == $past(s_q.cnt) || !$past(stretch_i) || !stretch_i)); // R10

endmodule

// File: rtl/tmo_flag.sv
module tmo_flag
    import scl_stretch_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_i,
    input  logic clear_i,
    output logic flag_o,
    output logic abort_o
);

    tmo_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.abort = hit_i && !s_q.flag;
        s_d.flag  = hit_i || (s_q.flag && !clear_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o  = s_q.flag;
    assign abort_o = s_q.abort;

    AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |=> !abort_o); // R8
    AST_ABORT_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> flag_o); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !clear_i) |=> flag_o); // R6

endmodule

// File: rtl/scl_stretch_guard.sv
module scl_stretch_guard
    import scl_stretch_pkg::*;
#(
    parameter int LIMIT_W     = DEF_LIMIT_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [LIMIT_W-1:0] stretch_limit_i,
    input  logic               period_tick_i,
    input  logic               scl_release_i,
    input  logic               scl_sense_i,
    input  logic               tmo_clear_i,
    output logic               tmo_status_o,
    output logic               abort_req_o
);

    logic scl_level;
    logic stretching;
    logic hit;

    scl_sense_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_i   (scl_sense_i),
        .level_o (scl_level)
    );

    assign stretching = scl_release_i && !scl_level;

    stretch_counter #(
        .LIMIT_W (LIMIT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .limit_i   (stretch_limit_i),
        .tick_i    (period_tick_i),
        .stretch_i (stretching),
        .hit_o     (hit)
    );

    tmo_flag u_flag (
        .clk     (clk),
        .rst_n   (rst_n),
        .hit_i   (hit),
        .clear_i (tmo_clear_i),
        .flag_o  (tmo_status_o),
        .abort_o (abort_req_o)
    );

    AST_ZERO_LIMIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_limit_i == '0 && !tmo_status_o) |=> !abort_req_o || $past(stretch_limit_i) != '0); // R5
    AST_MASTER_LOW_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_release_i && !tmo_status_o) |=> !abort_req_o); // R4

endmodule

// File: tb/tb_scl_stretch_guard.sv
`timescale 1ns/1ps
module tb_scl_stretch_guard;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] limit = 16'd0;
    logic        tick = 1'b0;
    logic        rel = 1'b1;
    logic        sense = 1'b1;
    logic        clr = 1'b0;
    logic        status;
    logic        abort;

    int checks = 0;
    int errors = 0;
    int aborts = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    scl_stretch_guard dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .stretch_limit_i (limit),
        .period_tick_i   (tick),
        .scl_release_i   (rel),
        .scl_sense_i     (sense),
        .tmo_clear_i     (clr),
        .tmo_status_o    (status),
        .abort_req_o     (abort)
    );

    always @(negedge clk) if (abort) aborts++;

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic begin_stretch(logic [15:0] l);
        limit = l;
        rel   = 1'b1;
        sense = 1'b0;
        idle(4);
    endtask

    task automatic end_and_clear();
        sense = 1'b1;
        idle(4);
        clr = 1'b1;
        idle(1);
        clr = 1'b0;
        idle(2);
    endtask

    task automatic t_reset();
        check("R1 status after reset", status, 0);
        check("R1 abort after reset", abort, 0);
    endtask

    task automatic t_exact_count();
        int a0 = aborts;
        begin_stretch(16'd3);
        ticks(2); idle(4);
        check("R2 no timeout one tick short", status, 0);
        ticks(1); idle(4);
        check("R2 timeout at limit", status, 1);
        check("R8 one abort pulse", aborts - a0, 1);
        sense = 1'b1; idle(6);
        check("R6 status sticky after SCL high", status, 1);
        end_and_clear();
        check("R7 status cleared", status, 0);
    endtask

    task automatic t_sense_high_resets();
        begin_stretch(16'd3);
        ticks(2);
        sense = 1'b1; idle(4);
        sense = 1'b0; idle(4);
        ticks(2); idle(4);
        check("R3 high SCL restarts count", status, 0);
        ticks(1); idle(4);
        check("R3 fresh count reaches limit", status, 1);
        end_and_clear();
    endtask

    task automatic t_master_low();
        int a0 = aborts;
        begin_stretch(16'd3);
        rel = 1'b0;
        ticks(10); idle(4);
        check("R4 no count while master drives low", status, 0);
        rel = 1'b1;
        ticks(2);
        rel = 1'b0; idle(2);
        rel = 1'b1;
        ticks(2); idle(4);
        check("R4 master low restarts count", status, 0);
        check("R4 no abort", aborts - a0, 0);
        end_and_clear();
    endtask

    task automatic t_zero_limit();
        int a0 = aborts;
        begin_stretch(16'd0);
        ticks(200); idle(4);
        check("R5 zero limit no status", status, 0);
        check("R5 zero limit no abort", aborts - a0, 0);
        end_and_clear();
    endtask

    task automatic t_clear_during_hit();
        int a0 = aborts;
        begin_stretch(16'd3);
        ticks(5); idle(2);
        check("R9 set before clear", status, 1);
        clr = 1'b1; idle(1); clr = 1'b0; idle(3);
        check("R9 set wins over clear", status, 1);
        check("R9 no second abort", aborts - a0, 1);
        end_and_clear();
        check("R7 clear after stretch ends", status, 0);
        clr = 1'b1; idle(1); clr = 1'b0; idle(2);
        check("R7 clear with status low", status, 0);
    endtask

    task automatic t_full_scale();
        int a0 = aborts;
        begin_stretch(16'hFFFF);
        ticks(65534); idle(3);
        check("R10 no timeout at 65534", status, 0);
        ticks(1); idle(3);
        check("R10 timeout at 65535", status, 1);
        ticks(20); idle(3);
        check("R10 no wrap single abort", aborts - a0, 1);
        end_and_clear();
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_exact_count();
        t_sense_high_resets();
        t_master_low();
        t_zero_limit();
        t_clear_during_hit();
        t_full_scale();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule